// File: doc/BRIEF.md
# Bitline Stress Write-Bang Sequencer

This block is a built-in self-test engine for a RAM organised as `ROWS` x `COLS` words. It works on one column at a time. For each target cell it writes the inverse of the background, reads it back, and then issues a burst of writes of background data to a reserved row (row 0) of that same column. It then reads the target again. This makes the target the only cell in its column that holds opposite data while the bitline pair is hammered the other way, which exposes slow reads caused by weak precharge or equalization.

A run has two phases. The first phase uses the background word `SEED` and the second uses `~SEED`. Each phase starts by writing its background to every word of the array. The block drives the RAM's write enable, read enable, row, column and write data. It compares returned read data against a pipelined expected word and reports a sticky failure flag and a completion flag. Row 0 is written but never read, so it is never tested.

The RAM interface is a fixed-latency command bus rather than a stream: there is no back-pressure, one command is issued per cycle, and read data must return exactly one cycle after the read command.

Top module: `wb_seq`

## Requirements
- R1: After an accepted start, the first `ROWS*COLS` cycles are writes of `SEED` to every word. The order is row-fast: the row steps 0..ROWS-1, then the column advances from 0 to COLS-1.
- R2: A read is never issued to row 0.
- R3: Each target takes `NUM_SAC+4` cycles in this order: write `~bg` to the target, read the target, `NUM_SAC` writes, read the target, write `bg` to the target. Here `bg` is the current phase background.
- R4: The burst is `NUM_SAC` (default 5) consecutive writes of `bg` to row 0 of the target's column, with no read in between.
- R5: After the last target of the first phase, the array is scan-written with `~SEED`. The target pass then repeats with `bg = ~SEED`.
- R6: Targets are visited with the row stepping 1..ROWS-1 first, then the column advancing 0..COLS-1.
- R7: Read data is taken one cycle after the read command. Any mismatch sets `fail_o`, which stays set until the next accepted start clears it.
- R8: `done_o` rises in the cycle after the last command of the second phase. It then holds with no memory command until a start is accepted.
- R9: A start pulse while a run is in progress has no effect on the command sequence.
- R10: Write enable and read enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; accepted only when idle or done |
| done_o | output | 1 | Run complete |
| fail_o | output | 1 | Sticky read-mismatch flag |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_row_o | output | RW | RAM row address |
| mem_col_o | output | CW | RAM column address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after a read |

## Verification
The assertions assume that reset is released synchronously to `clk`. They also assume that `start_i` is a clean, defined level, which may arrive at any time, including mid-run. The bench drives `start_i` only at falling edges and deliberately pulses it during a run. It models the RAM with exactly one cycle of read latency and never returns undefined data. Faults are injected only through the read data of the bench's memory model: a cell that always reads inverted, and a cell that reads inverted only right after a write to row 0 of its column. The row-0 fault case confirms that the reserved row never influences the outcome.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_TGT  = 2'd2,
    ST_DONE = 2'd3
  } wb_state_e;
endpackage

// File: rtl/wb_addr_gen.sv
module wb_addr_gen #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [RW-1:0] base_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          last_o
);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      row_q <= base_i;
      col_q <= '0;
    end else if (adv_i) begin
      if (row_q == ROW_MAX) begin
        row_q <= base_i;
        col_q <= (col_q == COL_MAX) ? '0 : col_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign last_o = (row_q == ROW_MAX) && (col_q == COL_MAX);
endmodule

// File: rtl/wb_cmp.sv
module wb_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          fail_o
);
  logic          vld_q;
  logic [DW-1:0] exp_q;
  logic          fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      exp_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      exp_q <= exp_i;
      if (clr_i)
        fail_q <= 1'b0;
      else if (vld_q && (rdata_i != exp_q))
        fail_q <= 1'b1;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/wb_seq.sv
module wb_seq
  import wb_pkg::*;
#(
  parameter int          ROWS    = 4,
  parameter int          COLS    = 4,
  parameter int          DW      = 8,
  parameter int          NUM_SAC = 5,
  parameter logic [DW-1:0] SEED  = '0,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          done_o,
  output logic          fail_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [RW-1:0] mem_row_o,
  output logic [CW-1:0] mem_col_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int SW = $clog2(NUM_SAC + 4);
  localparam logic [SW-1:0] S_WINV  = '0;
  localparam logic [SW-1:0] S_RD1   = SW'(1);
  localparam logic [SW-1:0] S_RD2   = SW'(NUM_SAC + 2);
  localparam logic [SW-1:0] S_LAST  = SW'(NUM_SAC + 3);
  localparam logic [RW-1:0] ROW_ONE = RW'(1);

  wb_state_e     state_q;
  logic          phase_q;
  logic [SW-1:0] step_q;

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          last;
  logic          ag_clr, ag_adv;
  logic [RW-1:0] ag_base;
  logic          accept;
  logic [DW-1:0] bg;
  logic [DW-1:0] exp_w;

  assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign bg     = phase_q ? ~SEED : SEED;

  // address sequencing control
  always_comb begin
    ag_clr  = 1'b0;
    ag_adv  = 1'b0;
    ag_base = '0;
    unique case (state_q)
      ST_SCAN: begin
        ag_adv = 1'b1;
        if (last) begin
          ag_clr  = 1'b1;
          ag_base = ROW_ONE;
        end
      end
      ST_TGT: begin
        ag_base = ROW_ONE;
        if (step_q == S_LAST) begin
          ag_adv = 1'b1;
          if (last) begin
            ag_clr  = 1'b1;
            ag_base = '0;
          end
        end
      end
      default: ag_clr = accept;
    endcase
  end

  // memory command decode
  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_row_o   = row;
    mem_col_o   = col;
    mem_wdata_o = bg;
    exp_w       = ~bg;
    unique case (state_q)
      ST_SCAN: mem_we_o = 1'b1;
      ST_TGT: begin
        if (step_q == S_WINV) begin
          mem_we_o    = 1'b1;
          mem_wdata_o = ~bg;
        end else if ((step_q == S_RD1) || (step_q == S_RD2)) begin
          mem_re_o = 1'b1;
        end else if (step_q == S_LAST) begin
          mem_we_o = 1'b1;
        end else begin
          mem_we_o  = 1'b1;
          mem_row_o = '0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_SCAN: begin
          step_q <= '0;
          if (last) state_q <= ST_TGT;
        end
        ST_TGT: begin
          if (step_q == S_LAST) begin
            step_q <= '0;
            if (last) begin
              if (phase_q) begin
                state_q <= ST_DONE;
              end else begin
                phase_q <= 1'b1;
                state_q <= ST_SCAN;
              end
            end
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: begin
          if (accept) begin
            state_q <= ST_SCAN;
            phase_q <= 1'b0;
            step_q  <= '0;
          end
        end
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);

  wb_addr_gen #(.ROWS(ROWS), .COLS(COLS)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ag_clr),
    .adv_i  (ag_adv),
    .base_i (ag_base),
    .row_o  (row),
    .col_o  (col),
    .last_o (last)
  );

  wb_cmp #(.DW(DW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .rd_en_i (mem_re_o),
    .exp_i   (exp_w),
    .rdata_i (mem_rdata_i),
    .fail_o  (fail_o)
  );
endmodule

// File: rtl/wb_seq_chk.sv
module wb_seq_chk #(
  parameter int RW = 2,
  parameter int CW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic          fail_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [RW-1:0] mem_row_o,
  input logic [CW-1:0] mem_col_o,
  input logic [DW-1:0] mem_wdata_o
);
  assert_no_read_row0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> (mem_row_o != '0));

  assert_we_re_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_we_o && !mem_re_o));

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);

  assert_burst_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_row_o == '0 && $past(mem_we_o && mem_row_o == '0))
      |-> ($stable(mem_wdata_o) && $stable(mem_col_o)));

  assert_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> $past(mem_we_o));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_we_o));
endmodule

bind wb_seq wb_seq_chk #(.RW(RW), .CW(CW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_row_o   (mem_row_o),
  .mem_col_o   (mem_col_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_wb_seq.sv
`timescale 1ns/1ps
module test_wb_seq;
  localparam int R  = 4;
  localparam int C  = 4;
  localparam int DW = 8;
  localparam int NS = 5;
  localparam logic [DW-1:0] SEED = 8'hA5;
  localparam int RW = 2;
  localparam int CW = 2;
  localparam int SCN = R * C;
  localparam int STP = NS + 4;
  localparam int PH  = SCN + STP * (R - 1) * C;
  localparam int TOT = 2 * PH;

  // vector: {fault_type[1:0], fault_row[1:0], fault_col[1:0], expect_fail}
  localparam int NV = 5;
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 1'b0},
    {2'd1, 2'd2, 2'd1, 1'b1},
    {2'd1, 2'd0, 2'd3, 1'b0},
    {2'd2, 2'd3, 2'd3, 1'b1},
    {2'd1, 2'd3, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, fail, we, re;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata = '0;

  int checks = 0;
  int failures = 0;
  int f_type = 0;
  int f_row = 0;
  int f_col = 0;

  always #2 clk = ~clk;

  wb_seq #(.ROWS(R), .COLS(C), .DW(DW), .NUM_SAC(NS), .SEED(SEED)) i_wb_seq (
    .clk (clk), .rst_n (rst_n), .start_i (start), .done_o (done), .fail_o (fail),
    .mem_we_o (we), .mem_re_o (re), .mem_row_o (row), .mem_col_o (col),
    .mem_wdata_o (wdata), .mem_rdata_i (rdata)
  );

  // RAM model, one cycle read latency, optional read fault
  logic [DW-1:0] mem [R][C];
  logic          prev_sac = 1'b0;
  logic [CW-1:0] prev_col = '0;
  logic [DW-1:0] rd_v;
  always @(posedge clk) begin
    if (we) mem[row][col] <= wdata;
    if (re) begin
      rd_v = mem[row][col];
      if (f_type == 1 && int'(row) == f_row && int'(col) == f_col) rd_v = ~rd_v;
      if (f_type == 2 && int'(row) == f_row && int'(col) == f_col && prev_sac && prev_col == col)
        rd_v = ~rd_v;
      rdata <= rd_v;
    end
    prev_sac <= we && (row == '0);
    prev_col <= col;
  end

  // expected command {done, we, re, row, col, data} for cycle k after start
  function automatic logic [3+RW+CW+DW-1:0] exp_op(int k);
    int ph, j, t, tg, st, r, c;
    logic [DW-1:0] bgv;
    logic w, rd;
    logic [DW-1:0] d;
    ph = k / PH;
    j  = k % PH;
    bgv = (ph == 0) ? SEED : ~SEED;
    if (j < SCN) begin
      w = 1'b1; rd = 1'b0; r = j % R; c = j / R; d = bgv;
    end else begin
      t  = j - SCN;
      tg = t / STP;
      st = t % STP;
      r  = 1 + tg % (R - 1);
      c  = tg / (R - 1);
      w = 1'b1; rd = 1'b0; d = bgv;
      if (st == 0) d = ~bgv;
      else if (st == 1 || st == NS + 2) begin w = 1'b0; rd = 1'b1; d = '0; end
      else if (st != NS + 3) r = 0;
    end
    return {1'b0, w, rd, RW'(r), CW'(c), d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_test(input int ft, input int fr, input int fc, input bit expf,
                          input int mid_k, input bit chk_clr);
    int bad;
    logic [3+RW+CW+DW-1:0] obs, ex, first_obs, first_ex;
    f_type = ft; f_row = fr; f_col = fc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    bad = 0; first_obs = '0; first_ex = '0;
    for (int k = 0; k < TOT; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0 && chk_clr) begin
        // R7: accepted start clears a sticky fail
        check(!fail && !done, "R7 clear on start", {30'd0, fail, done}, 32'd0);
      end
      obs = {done, we, re, row, col, we ? wdata : {DW{1'b0}}};
      ex  = exp_op(k);
      if (obs != ex) begin
        if (bad == 0) begin first_obs = obs; first_ex = ex; end
        bad++;
      end
      if (k == mid_k) start = 1'b1;
      else start = 1'b0;
    end
    // R1 R3 R4 R5 R6 R9: full command trace
    check(bad == 0, "R1 R3 R4 R5 R6 R9 trace", 32'(first_obs), 32'(first_ex));
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 done after last", {31'd0, done}, 32'd1);
    check(fail == expf, "R7 R2 fail result", {31'd0, fail}, {31'd0, expf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!done && !fail, "R8 reset flags", {30'd0, done, fail}, 32'd0);
    check(!we && !re, "R10 reset idle", {30'd0, we, re}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!we && !re && !done, "R8 idle without start", {29'd0, we, re, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_test(int'(VEC[v][6:5]), int'(VEC[v][4:3]), int'(VEC[v][2:1]), VEC[v][0], -1, 1'b0);
    end

    // R8: done holds, no commands while done
    repeat (5) @(negedge clk);
    check(done && !we && !re, "R8 done hold quiet", {29'd0, done, we, re}, 32'h4);

    // R7: previous run failed; a new clean run clears it at start
    check(fail == 1'b1, "R7 sticky before restart", {31'd0, fail}, 32'd1);
    run_test(0, 0, 0, 1'b0, -1, 1'b1);

    // R9: start pulse in the middle of a run is ignored
    run_test(0, 0, 0, 1'b0, 50, 1'b0);
    // R9: start pulse during the second phase with a fault present
    run_test(2, 1, 2, 1'b1, PH + 20, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule